// File: doc/BRIEF.md
# Serial Flash Command Engine

This block issues one short command at a time to a serial flash device over a single-lane SPI link. Typical commands are an identification or status read, a write-enable, or an erase. The host writes an address register and two 32-bit outgoing data registers. It then writes a control word that selects the opcode and the optional phases. A write with the execute bit set launches the command.

A sequencer walks the enabled phases in order: opcode, address, dummy clocks, outgoing data, then incoming data. For each piece it hands a byte, or a group of up to eight dummy clocks, to a bit shifter through a start/busy handshake. Incoming bytes land in two 32-bit holding registers. A status bit stays high while the command runs. While it is high, every register write is refused.

Top module: `fce_engine`

## Requirements
- R1: Register select: 0 is the control word, 1 the address, 2 the lower outgoing data, 3 the upper outgoing data. Control word fields: [7:0] opcode, [8] read enable, [11:9] read count, [12] address enable, [14:13] address count, [15] write enable, [18:16] write count, [23:19] dummy clocks, [24] execute. All counts are zero-based, so 0 means one byte.
- R2: A control write with bit 24 clear only stores the word. No chip select, serial clock or in-progress indication follows.
- R3: A control write with bit 24 set while idle raises `in_progress` and drives `spi_cs_n` low on the next cycle. When the last phase ends, `spi_cs_n` rises, then `in_progress` clears and `eng_idle` is 1.
- R4: The phases run as opcode, address, dummy, outgoing data, incoming data. A disabled phase is skipped, and a dummy count of 0 means no dummy phase. The opcode is always sent, most significant bit first, with `spi_mosi_oe` high.
- R5: The address phase sends address-count+1 bytes taken from the low end of the address register, the most significant of those bytes first.
- R6: The dummy phase gives exactly the programmed number of serial clocks (0 to 31) with `spi_mosi_oe` low.
- R7: The outgoing data phase sends write-count+1 bytes. Byte k is taken from bits [8k+7:8k] of {upper, lower}, so byte 0 comes from lower[7:0] and byte 4 from upper[7:0]. Bytes go out lowest index first, each most significant bit first.
- R8: The incoming data phase samples read-count+1 bytes on rising serial clock edges, most significant bit first, into bits [8k+7:8k] of {`rdata_hi`, `rdata_lo`}. Both holding registers clear at execute, so byte slots that are not received read 0.
- R9: The link uses SPI mode 0. The serial clock is low whenever chip select is high, each clock level lasts HALF_DIV system clocks, and data changes only while the clock is low.
- R10: While `in_progress` is 1, writes to every register are ignored, including a second execute request.
- R11: `rdata_lo` and `rdata_hi` hold their values while no command is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write value |
| rdata_lo | output | 32 | Incoming data bytes 0 to 3 |
| rdata_hi | output | 32 | Incoming data bytes 4 to 7 |
| in_progress | output | 1 | Command running |
| eng_idle | output | 1 | Engine idle with chip select released |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_mosi_oe | output | 1 | Output enable for spi_mosi |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The commands tried are a bare opcode, an opcode with a three-byte read, a full read with a three-byte address, ten dummy clocks and eight incoming bytes, a write with a four-byte address and five outgoing bytes, and a mixed command with a one-byte address, 31 dummy clocks, one outgoing byte and two incoming bytes. The bare opcode separates phase skipping from phase emission. The address widths of one, three and four bytes expose errors in byte order and byte selection. The dummy counts of 10 and 31 are not multiples of eight, so they test how the clocks are split into groups of up to eight. Read lengths of two, three and eight bytes show whether unused slots are cleared. A reference model in the bench rebuilds the expected bit stream and compares it bit by bit, phase by phase, against what a flash model sees. A further command receives an address write and a second execute while it runs. Both must leave no trace.

// File: rtl/fce_pkg.sv
package fce_pkg;

  localparam int BYTE_W     = 8;
  localparam int WORD_W     = 32;
  localparam int WIN_BYTES  = 8;
  localparam int WIN_W      = WIN_BYTES * BYTE_W;
  localparam int IDX_W      = $clog2(WIN_BYTES);
  localparam int DUMMY_W    = 5;
  localparam int NBITS_W    = $clog2(BYTE_W) + 1;
  localparam int CTRL_W     = 25;

  typedef struct packed {
    logic               exec;
    logic [DUMMY_W-1:0] dummy;
    logic [IDX_W-1:0]   wr_cnt;
    logic               wr_en;
    logic [1:0]         ad_cnt;
    logic               ad_en;
    logic [IDX_W-1:0]   rd_cnt;
    logic               rd_en;
    logic [BYTE_W-1:0]  opcode;
  } ctrl_t;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_WLO  = 2'd2,
    SEL_WHI  = 2'd3
  } regsel_e;

  typedef enum logic [2:0] {
    PH_OPC, PH_ADDR, PH_DUMMY, PH_WR, PH_RD, PH_END
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_RUN, ST_HOLD
  } state_e;

  // Next enabled phase after ph.
  function automatic phase_e next_phase(phase_e ph, ctrl_t c);
    if (ph == PH_OPC && c.ad_en) return PH_ADDR;
    if ((ph == PH_OPC || ph == PH_ADDR) && c.dummy != '0) return PH_DUMMY;
    if ((ph == PH_OPC || ph == PH_ADDR || ph == PH_DUMMY) && c.wr_en) return PH_WR;
    if (ph != PH_RD && ph != PH_END && c.rd_en) return PH_RD;
    return PH_END;
  endfunction

  // Address byte for step idx: most significant selected byte goes first.
  function automatic logic [BYTE_W-1:0] addr_byte(logic [WORD_W-1:0] a,
                                                   logic [1:0] cnt,
                                                   logic [IDX_W-1:0] idx);
    logic [1:0]        pos;
    logic [WORD_W-1:0] sh;
    pos = cnt - idx[1:0];
    sh  = a >> {pos, 3'b000};
    return sh[BYTE_W-1:0];
  endfunction

  // Dummy clocks handed to the shifter in one go.
  function automatic logic [NBITS_W-1:0] dummy_chunk(logic [DUMMY_W-1:0] left);
    if (left > DUMMY_W'(BYTE_W)) return NBITS_W'(BYTE_W);
    return left[NBITS_W-1:0];
  endfunction

endpackage

// File: rtl/fce_shift.sv
module fce_shift
  import fce_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [BYTE_W-1:0]  tx_byte,
  input  logic [NBITS_W-1:0] nbits,
  input  logic               drive,
  input  logic               miso,
  output logic               busy,
  output logic               done,
  output logic [BYTE_W-1:0]  rx_byte,
  output logic               sclk,
  output logic               mosi,
  output logic               mosi_oe
);

  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(HALF_DIV - 1);

  logic [CW-1:0]      cnt_q;
  logic [NBITS_W-1:0] left_q;
  logic [BYTE_W-1:0]  tx_q, rx_q;
  logic               busy_q, done_q, sclk_q, drv_q;
  logic               half_end;

  assign half_end = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      left_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sclk_q <= 1'b0;
      drv_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          tx_q   <= tx_byte;
          left_q <= nbits;
          cnt_q  <= CNT_TOP;
          sclk_q <= 1'b0;
          drv_q  <= drive;
          rx_q   <= '0;
        end
      end else if (!half_end) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        cnt_q <= CNT_TOP;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[BYTE_W-2:0], miso};
        end else begin
          sclk_q <= 1'b0;
          tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
          left_q <= left_q - 1'b1;
          if (left_q == NBITS_W'(1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_byte = rx_q;
  assign sclk    = sclk_q;
  assign mosi_oe = busy_q & drv_q;
  assign mosi    = busy_q & drv_q & tx_q[BYTE_W-1];

endmodule

// File: rtl/fce_regs.sv
module fce_regs
  import fce_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic              locked,
  output ctrl_t             ctrl_q,
  output logic [WORD_W-1:0] addr_q,
  output logic [WIN_W-1:0]  wdata_q,
  output logic              exec_go
);

  logic wr_ok;
  assign wr_ok   = reg_we && !locked;
  assign exec_go = wr_ok && (regsel_e'(reg_sel) == SEL_CTRL) && reg_wdata[CTRL_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (wr_ok) begin
      case (regsel_e'(reg_sel))
        SEL_CTRL: ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
        SEL_ADDR: addr_q <= reg_wdata;
        SEL_WLO:  wdata_q[WORD_W-1:0] <= reg_wdata;
        default:  wdata_q[WIN_W-1:WORD_W] <= reg_wdata;
      endcase
    end
  end

endmodule

// File: rtl/fce_seq.sv
module fce_seq
  import fce_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exec_go,
  input  ctrl_t              ctrl,
  input  logic [WORD_W-1:0]  addr,
  input  logic [WIN_W-1:0]   wdata,
  input  logic               sh_busy,
  input  logic               sh_done,
  input  logic [BYTE_W-1:0]  sh_rx,
  output logic               sh_start,
  output logic [BYTE_W-1:0]  sh_tx,
  output logic [NBITS_W-1:0] sh_nbits,
  output logic               sh_drive,
  output logic               cs_n,
  output logic               in_progress,
  output logic               eng_idle,
  output logic [WIN_W-1:0]   rdata
);

  state_e             state_q;
  phase_e             phase_q, nph;
  logic [IDX_W-1:0]   idx_q;
  logic [DUMMY_W-1:0] dleft_q;
  logic               pending_q, cs_n_q, last_piece;
  logic [WIN_W-1:0]   rdata_q;
  logic [NBITS_W-1:0] chunk;

  assign nph      = next_phase(phase_q, ctrl);
  assign chunk    = dummy_chunk(dleft_q);
  assign sh_start = (state_q == ST_RUN) && !pending_q && !sh_busy && (phase_q != PH_END);

  always_comb begin
    sh_tx    = '0;
    sh_nbits = NBITS_W'(BYTE_W);
    sh_drive = 1'b1;
    case (phase_q)
      PH_OPC:   sh_tx = ctrl.opcode;
      PH_ADDR:  sh_tx = addr_byte(addr, ctrl.ad_cnt, idx_q);
      PH_DUMMY: begin sh_nbits = chunk; sh_drive = 1'b0; end
      PH_WR:    sh_tx = wdata[{idx_q, 3'b000} +: BYTE_W];
      default:  sh_drive = 1'b0;
    endcase
  end

  always_comb begin
    case (phase_q)
      PH_ADDR:  last_piece = (idx_q == {1'b0, ctrl.ad_cnt});
      PH_DUMMY: last_piece = ({1'b0, chunk} == dleft_q);
      PH_WR:    last_piece = (idx_q == ctrl.wr_cnt);
      PH_RD:    last_piece = (idx_q == ctrl.rd_cnt);
      default:  last_piece = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_END;
      idx_q     <= '0;
      dleft_q   <= '0;
      pending_q <= 1'b0;
      cs_n_q    <= 1'b1;
      rdata_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (exec_go) begin
            state_q   <= ST_RUN;
            phase_q   <= PH_OPC;
            idx_q     <= '0;
            pending_q <= 1'b0;
            cs_n_q    <= 1'b0;
            rdata_q   <= '0;
          end
        end
        ST_RUN: begin
          if (sh_start) pending_q <= 1'b1;
          if (sh_done) begin
            pending_q <= 1'b0;
            if (phase_q == PH_RD) rdata_q[{idx_q, 3'b000} +: BYTE_W] <= sh_rx;
            if (phase_q == PH_DUMMY) dleft_q <= dleft_q - DUMMY_W'(chunk);
            if (last_piece) begin
              phase_q <= nph;
              idx_q   <= '0;
              if (nph == PH_DUMMY) dleft_q <= ctrl.dummy;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
          if (phase_q == PH_END && !pending_q) begin
            state_q <= ST_HOLD;
            cs_n_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_n        = cs_n_q;
  assign in_progress = (state_q != ST_IDLE);
  assign eng_idle    = (state_q == ST_IDLE) && cs_n_q;
  assign rdata       = rdata_q;

endmodule

// File: rtl/fce_engine.sv
module fce_engine
  import fce_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] rdata_lo,
  output logic [31:0] rdata_hi,
  output logic        in_progress,
  output logic        eng_idle,
  output logic        spi_cs_n,
  output logic        spi_sclk,
  output logic        spi_mosi,
  output logic        spi_mosi_oe,
  input  logic        spi_miso
);

  ctrl_t              ctrl_q;
  logic [WORD_W-1:0]  addr_q;
  logic [WIN_W-1:0]   wdata_q, rdata_w;
  logic               exec_go;
  logic               sh_start, sh_busy, sh_done, sh_drive;
  logic [BYTE_W-1:0]  sh_tx, sh_rx;
  logic [NBITS_W-1:0] sh_nbits;

  fce_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .locked    (in_progress),
    .ctrl_q    (ctrl_q),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .exec_go   (exec_go)
  );

  fce_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .exec_go     (exec_go),
    .ctrl        (ctrl_q),
    .addr        (addr_q),
    .wdata       (wdata_q),
    .sh_busy     (sh_busy),
    .sh_done     (sh_done),
    .sh_rx       (sh_rx),
    .sh_start    (sh_start),
    .sh_tx       (sh_tx),
    .sh_nbits    (sh_nbits),
    .sh_drive    (sh_drive),
    .cs_n        (spi_cs_n),
    .in_progress (in_progress),
    .eng_idle    (eng_idle),
    .rdata       (rdata_w)
  );

  fce_shift #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (sh_start),
    .tx_byte (sh_tx),
    .nbits   (sh_nbits),
    .drive   (sh_drive),
    .miso    (spi_miso),
    .busy    (sh_busy),
    .done    (sh_done),
    .rx_byte (sh_rx),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .mosi_oe (spi_mosi_oe)
  );

  assign rdata_lo = rdata_w[WORD_W-1:0];
  assign rdata_hi = rdata_w[WIN_W-1:WORD_W];

endmodule

// File: rtl/fce_engine_chk.sv
module fce_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [1:0]  reg_sel,
  input logic [31:0] reg_wdata,
  input logic        in_progress,
  input logic        eng_idle,
  input logic        spi_cs_n,
  input logic        spi_sclk,
  input logic        spi_mosi_oe,
  input logic [31:0] rdata_lo,
  input logic [31:0] rdata_hi,
  input logic [24:0] ctrl_q,
  input logic [31:0] addr_q
);

  logic exec_req, load_req;
  assign exec_req = reg_we && (reg_sel == 2'd0) && reg_wdata[24];
  assign load_req = reg_we && (reg_sel == 2'd0) && !reg_wdata[24];

  p_exec_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exec_req && !in_progress |=> in_progress && !spi_cs_n);

  p_load_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_req && !in_progress |=> !in_progress);

  p_idle_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_idle |-> spi_cs_n && !in_progress);

  p_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_progress |=> $stable(ctrl_q) && $stable(addr_q));

  p_sclk_rest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  p_drive_in_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    spi_mosi_oe |-> !spi_cs_n);

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_progress && !exec_req |=> $stable(rdata_lo) && $stable(rdata_hi));

endmodule

bind fce_engine fce_engine_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_we      (reg_we),
  .reg_sel     (reg_sel),
  .reg_wdata   (reg_wdata),
  .in_progress (in_progress),
  .eng_idle    (eng_idle),
  .spi_cs_n    (spi_cs_n),
  .spi_sclk    (spi_sclk),
  .spi_mosi_oe (spi_mosi_oe),
  .rdata_lo    (rdata_lo),
  .rdata_hi    (rdata_hi),
  .ctrl_q      (ctrl_q),
  .addr_q      (addr_q)
);

// File: tb/fce_engine_bench.sv
module fce_engine_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] rdata_lo, rdata_hi;
  logic        in_progress, eng_idle, spi_cs_n, spi_sclk, spi_mosi, spi_mosi_oe;
  logic        spi_miso;

  always #(CLK_PERIOD/2) clk = ~clk;

  fce_engine #(.HALF_DIV(HALF)) u_fce_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .rdata_lo(rdata_lo), .rdata_hi(rdata_hi),
    .in_progress(in_progress), .eng_idle(eng_idle), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_mosi_oe(spi_mosi_oe),
    .spi_miso(spi_miso)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Flash model: response bit k is driven from chip select fall / k-th falling clock.
  function automatic bit bit_at(int i, int s);
    return ((i * 5 + s) % 7) > 2;
  endfunction

  int fcount = 0;
  int seed = 0;
  always @(negedge spi_cs_n) fcount = 0;
  always @(negedge spi_sclk) fcount = fcount + 1;
  assign spi_miso = bit_at(fcount, seed);

  // Bit capture on the flash side.
  bit  cap_mosi[$];
  bit  cap_oe[$];
  time t_rise = 0;
  int  bad_width = 0;
  int  bad_cs = 0;
  always @(posedge spi_sclk) begin
    cap_mosi.push_back(spi_mosi);
    cap_oe.push_back(spi_mosi_oe);
    t_rise = $time;
    if (spi_cs_n !== 1'b0) bad_cs++;
  end
  always @(negedge spi_sclk) begin
    if (t_rise > 0 && ($time - t_rise) != HALF * CLK_PERIOD) bad_width++;
  end

  // Reference stream.
  bit exp_mosi[$];
  bit exp_oe[$];
  int exp_seg[$];
  string tags[5] = '{"R4", "R5", "R6", "R7", "R8"};

  task automatic push_byte(input logic [7:0] b, input bit oe, input int sg);
    for (int k = 7; k >= 0; k--) begin
      exp_mosi.push_back(b[k]);
      exp_oe.push_back(oe);
      exp_seg.push_back(sg);
    end
  endtask

  function automatic logic [31:0] mk(input logic [7:0] op, input bit rd, input int rc,
                                     input bit ad, input int ac, input bit wr, input int wc,
                                     input int dm);
    logic [31:0] w;
    w = 32'd0;
    w[7:0]   = op;
    w[8]     = rd;
    w[11:9]  = 3'(rc);
    w[12]    = ad;
    w[14:13] = 2'(ac);
    w[15]    = wr;
    w[18:16] = 3'(wc);
    w[23:19] = 5'(dm);
    return w;
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic run_cmd(input string name, input logic [31:0] cw, input logic [31:0] a,
                         input logic [63:0] wd, input int sd, input bit set_regs,
                         input bit inject);
    int nr, rstart, cyc;
    logic [63:0] exp_rd;
    seed = sd;
    if (set_regs) begin
      wr(2'd1, a);
      wr(2'd2, wd[31:0]);
      wr(2'd3, wd[63:32]);
    end
    cap_mosi.delete(); cap_oe.delete();
    exp_mosi.delete(); exp_oe.delete(); exp_seg.delete();
    push_byte(cw[7:0], 1'b1, 0);
    if (cw[12]) begin
      for (int i = 0; i <= int'(cw[14:13]); i++)
        push_byte(8'(a >> (8 * (int'(cw[14:13]) - i))), 1'b1, 1);
    end
    for (int i = 0; i < int'(cw[23:19]); i++) begin
      exp_mosi.push_back(1'b0); exp_oe.push_back(1'b0); exp_seg.push_back(2);
    end
    if (cw[15]) begin
      for (int i = 0; i <= int'(cw[18:16]); i++) push_byte(wd[8*i +: 8], 1'b1, 3);
    end
    nr = cw[8] ? int'(cw[11:9]) + 1 : 0;
    rstart = exp_mosi.size();
    for (int i = 0; i < nr; i++) push_byte(8'h00, 1'b0, 4);

    wr(2'd0, cw | 32'h0100_0000);
    chk(in_progress === 1'b1 && spi_cs_n === 1'b0, "R3", {name, " start"},
        {62'd0, in_progress, spi_cs_n}, 64'h2);
    if (inject) begin
      repeat (6) @(negedge clk);
      wr(2'd1, 32'hDEAD_BEEF);
      wr(2'd0, mk(8'h05, 1, 0, 0, 0, 0, 0, 0) | 32'h0100_0000);
    end
    cyc = 0;
    while (in_progress && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    chk(!in_progress && spi_cs_n === 1'b1 && eng_idle === 1'b1, "R3", {name, " end"},
        {61'd0, in_progress, spi_cs_n, eng_idle}, 64'h3);
    chk(cap_mosi.size() == exp_mosi.size(), "R1,R4", {name, " clock count"},
        64'(cap_mosi.size()), 64'(exp_mosi.size()));
    for (int sg = 0; sg < 5; sg++) begin
      int cnt, bad;
      cnt = 0; bad = 0;
      for (int i = 0; i < exp_mosi.size(); i++) begin
        if (exp_seg[i] == sg) begin
          cnt++;
          if (i >= cap_mosi.size()) bad++;
          else if (cap_oe[i] != exp_oe[i] || (exp_oe[i] && cap_mosi[i] != exp_mosi[i])) bad++;
        end
      end
      if (cnt > 0) chk(bad == 0, tags[sg], {name, " phase bits"}, 64'(bad), 64'd0);
    end
    exp_rd = 64'd0;
    for (int k = 0; k < nr; k++)
      for (int b = 0; b < 8; b++)
        exp_rd[8*k + 7 - b] = bit_at(rstart + 8*k + b, sd);
    chk({rdata_hi, rdata_lo} == exp_rd, "R8", {name, " read data"},
        {rdata_hi, rdata_lo}, exp_rd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R3: actual hung expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] hold;
    int sz;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(spi_cs_n === 1'b1 && spi_sclk === 1'b0 && in_progress === 1'b0 && eng_idle === 1'b1,
        "R3", "reset state", {60'd0, spi_cs_n, spi_sclk, in_progress, eng_idle}, 64'h9);
    chk({rdata_hi, rdata_lo} === 64'd0, "R8", "reset read data", {rdata_hi, rdata_lo}, 64'd0);

    // R2: load without execute
    cap_mosi.delete();
    wr(2'd0, mk(8'h06, 0, 0, 0, 0, 0, 0, 0));
    repeat (30) @(negedge clk);
    chk(!in_progress && spi_cs_n === 1'b1 && cap_mosi.size() == 0, "R2", "load only",
        64'(cap_mosi.size()), 64'd0);

    run_cmd("opcode only", mk(8'h06, 0, 0, 0, 0, 0, 0, 0), 32'h0, 64'h0, 1, 1, 0);
    run_cmd("id read", mk(8'h9F, 1, 2, 0, 0, 0, 0, 0), 32'h0, 64'h0, 2, 1, 0);
    run_cmd("fast read", mk(8'h0B, 1, 7, 1, 2, 0, 0, 10), 32'h0012_3456, 64'h0, 3, 1, 0);
    run_cmd("program", mk(8'h12, 0, 0, 1, 3, 1, 4, 0), 32'hA1B2_C3D4,
            64'h8877_6655_4433_2211, 4, 1, 0);
    run_cmd("mixed", mk(8'h5A, 1, 1, 1, 0, 1, 0, 31), 32'h0000_0077,
            64'h0000_0000_0000_00C3, 5, 1, 0);

    // R10: writes during a command are ignored
    run_cmd("busy inject", mk(8'h9F, 1, 3, 1, 1, 0, 0, 3), 32'h0000_4321, 64'h0, 6, 1, 1);
    sz = cap_mosi.size();
    repeat (40) @(negedge clk);
    chk(!in_progress && cap_mosi.size() == sz, "R10", "second execute ignored",
        64'(cap_mosi.size()), 64'(sz));
    run_cmd("R10 address kept", mk(8'h03, 1, 0, 1, 1, 0, 0, 0), 32'h0000_4321, 64'h0, 7, 0, 0);

    // R11: read data holds while idle, across data register writes
    hold = {rdata_hi, rdata_lo};
    wr(2'd2, 32'h1234_5678);
    wr(2'd3, 32'h9ABC_DEF0);
    repeat (20) @(negedge clk);
    chk({rdata_hi, rdata_lo} == hold, "R11", "read data hold", {rdata_hi, rdata_lo}, hold);

    chk(bad_width == 0 && bad_cs == 0, "R9", "clock level width and select",
        64'(bad_width + bad_cs), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule